// File: doc/BRIEF.md
# Register-Machine Processor Core

This block is a small sequential processor that runs programs for a nine-instruction register machine. Its state is a 16-bit program counter and a bank of 64 signed two's-complement data locations. A program is written into an internal instruction memory through a write port. The data locations are preloaded and read back through a debug port. After a start pulse, the core fetches, decodes and executes one instruction at a time until it reaches a halt, and then raises a halted flag.

Each instruction is one 32-bit word. Bits [31:28] hold the opcode, bits [27:22] hold operand location `a`, bits [21:16] hold operand location `b`, and bits [15:0] hold the jump target. The opcodes are:

- 0 halt
- 1 copy
- 2 add
- 3 subtract
- 4 multiply
- 5 divide with remainder
- 6 jump
- 7 jump if zero
- 8 jump if positive

Opcodes 9 to 15 also act as halt. Division uses a multi-cycle shift-subtract unit and holds the program counter while it works. Every other instruction completes in a single clock.

Top module: `regmach_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and clears `halted`. The core then stays idle, with the counter at 0, until `start` is sampled high.
- R2: Opcode 0 and opcodes 9 to 15 halt the core. The program counter and every data location keep their values, and `halted` stays high until reset, even if `start` is pulsed again.
- R3: Opcode 1 copies location `b` into location `a` and advances the program counter by one. Every instruction other than a divide with a nonzero divisor completes in one cycle.
- R4: Opcode 2 stores a+b into `a`, opcode 3 stores a−b into `a`, and opcode 4 stores a×b into `a`. Each keeps the low 32 bits of the result and advances the program counter by one.
- R5: An instruction changes no data location other than its destination or destinations.
- R6: Opcode 5 with a nonzero divisor stores the floor quotient a/b into `a` and the remainder into `b`. The quotient rounds toward minus infinity and the remainder takes the sign of the divisor. For example, 7 and −2 give −4 and −1, and −2^31 divided by −1 gives −2^31 and 0.
- R7: When a divide names the same location as both operands, that location ends up holding the remainder.
- R8: A divide with a zero divisor takes one cycle, writes 0 to `a`, and then writes the original dividend to `b`.
- R9: A divide with a nonzero divisor keeps the program counter unchanged for DATA_W+1 cycles after the issue cycle. Its results and the counter increment appear together at the last of those cycles.
- R10: Opcode 6 loads the program counter with the target field.
- R11: Opcode 7 loads the target when location `a` equals 0. Otherwise it advances the program counter by one.
- R12: Opcode 8 loads the target only when location `a` is strictly greater than 0. A value of zero or a negative value falls through to the next instruction.
- R13: `dbg_rdata` always shows the location selected by `dbg_addr`. A debug write takes effect only while the core is idle or halted and is ignored while a program runs.
- R14: When `start` is sampled high in the idle state, the instruction at address 0 executes on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins execution when the core is idle |
| imem_we | input | 1 | Instruction memory write enable |
| imem_addr | input | IMEM_AW | Instruction memory write address |
| imem_wdata | input | 32 | Instruction word to write |
| dbg_we | input | 1 | Debug write enable for data locations |
| dbg_addr | input | 6 | Debug location select |
| dbg_wdata | input | DATA_W | Debug write value |
| dbg_rdata | output | DATA_W | Value of the selected location |
| pc | output | 16 | Program counter |
| halted | output | 1 | High once a halt has executed |

## Verification
The embedded assertions check the control flow on every cycle:
- the counter is zero while idle;
- a halt is permanent and freezes the counter;
- each data operation advances the counter by one;
- a jump lands on its target;
- a failed jump-if-zero falls through;
- the counter holds while the divider iterates.

The arithmetic itself can only be shown by the bench's scenarios. These include wrap-around sums and products, floor rounding in all four sign combinations, the remainder's priority on a shared location, zero divisors and the most-negative-over-minus-one case. They also cover a debug write attempted during a divide and a second start pulse given after a halt. A behavioural model in the bench follows the counter and the halted flag cycle by cycle.

// File: rtl/regmach_core.sv
module regmach_core #(
  parameter int DATA_W  = 32,
  parameter int IMEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              imem_we,
  input  logic [IMEM_AW-1:0] imem_addr,
  input  logic [31:0]       imem_wdata,
  input  logic              dbg_we,
  input  logic [5:0]        dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic [15:0]       pc,
  output logic              halted
);
  localparam int NLOC  = 64;
  localparam int CNT_W = $clog2(DATA_W);
  localparam int MSB   = DATA_W - 1;

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_DIV, S_FIN, S_HALT} st_t;

  st_t st;
  logic [31:0] imem [2**IMEM_AW];
  logic signed [DATA_W-1:0] bank [NLOC];

  logic [31:0] instr;
  logic [3:0]  op;
  logic [5:0]  fa, fb;
  logic [15:0] tgt;
  logic signed [DATA_W-1:0] va, vb;

  assign instr = imem[pc[IMEM_AW-1:0]];
  assign op  = instr[31:28];
  assign fa  = instr[27:22];
  assign fb  = instr[21:16];
  assign tgt = instr[15:0];
  assign va  = bank[fa];
  assign vb  = bank[fb];
  assign dbg_rdata = bank[dbg_addr];
  assign halted = (st == S_HALT);

  logic signed [DATA_W-1:0] dvd, dvs;
  logic [5:0] da, db;
  logic [DATA_W-1:0] quo, rem, dmag, qt, rt, qf, rf;
  logic [DATA_W:0] rem_sh;
  logic [CNT_W-1:0] cnt;
  logic take, qneg, fix;

  assign dmag   = dvs[MSB] ? -dvs : dvs;
  assign rem_sh = {rem, quo[MSB]};
  assign take   = rem_sh >= {1'b0, dmag};
  assign qneg   = dvd[MSB] ^ dvs[MSB];
  assign qt     = qneg ? -quo : quo;
  assign rt     = dvd[MSB] ? -rem : rem;
  assign fix    = qneg && (rem != '0);
  assign qf     = fix ? qt - 1'b1 : qt;
  assign rf     = fix ? rt + dvs : rt;

  always_ff @(posedge clk)
    if (imem_we) imem[imem_addr] <= imem_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_IDLE;
      pc  <= '0;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) st <= S_RUN;
        S_RUN: begin
          case (op)
            4'd1, 4'd2, 4'd3, 4'd4: pc <= pc + 16'd1;
            4'd5: begin
              if (vb == '0) pc <= pc + 16'd1;
              else begin
                st  <= S_DIV;
                dvd <= va;
                dvs <= vb;
                da  <= fa;
                db  <= fb;
                cnt <= '0;
                quo <= va[MSB] ? -va : va;
                rem <= '0;
              end
            end
            4'd6: pc <= tgt;
            4'd7: pc <= (va == '0) ? tgt : pc + 16'd1;
            4'd8: pc <= (va > 0) ? tgt : pc + 16'd1;
            default: st <= S_HALT;
          endcase
        end
        S_DIV: begin
          rem <= take ? DATA_W'(rem_sh - {1'b0, dmag}) : rem_sh[DATA_W-1:0];
          quo <= {quo[DATA_W-2:0], take};
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(DATA_W - 1)) st <= S_FIN;
        end
        S_FIN: begin
          pc <= pc + 16'd1;
          st <= S_RUN;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (dbg_we && (st == S_IDLE || st == S_HALT)) bank[dbg_addr] <= dbg_wdata;
    if (!rst && st == S_RUN) begin
      case (op)
        4'd1: bank[fa] <= vb;
        4'd2: bank[fa] <= va + vb;
        4'd3: bank[fa] <= va - vb;
        4'd4: bank[fa] <= va * vb;
        4'd5: if (vb == '0) begin
          bank[fa] <= '0;
          bank[fb] <= va;
        end
        default: ;
      endcase
    end
    if (!rst && st == S_FIN) begin
      bank[da] <= qf;
      bank[db] <= rf;
    end
  end

  AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (rst) (st == S_IDLE) |-> (pc == 16'd0 && !halted)); // R1
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst) halted |=> (halted && $stable(pc))); // R2
  AST_DATA_STEP: assert property (@(posedge clk) disable iff (rst) (st == S_RUN && op >= 4'd1 && op <= 4'd4) |=> (pc == $past(pc) + 16'd1)); // R3
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst) (st == S_DIV) |=> $stable(pc)); // R9
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst) (st == S_RUN && op == 4'd6) |=> (pc == $past(tgt))); // R10
  AST_JZ_FALL: assert property (@(posedge clk) disable iff (rst) (st == S_RUN && op == 4'd7 && va != '0) |=> (pc == $past(pc) + 16'd1)); // R11
endmodule

// File: tb/tb_regmach_core.sv
module tb_regmach_core;
  localparam int DW = 32;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst, start, imem_we, dbg_we;
  logic [AW-1:0] imem_addr;
  logic [31:0] imem_wdata;
  logic [5:0] dbg_addr;
  logic [DW-1:0] dbg_wdata, dbg_rdata;
  logic [15:0] pc;
  logic halted;

  regmach_core #(.DATA_W(DW), .IMEM_AW(AW)) dut (
    .clk(clk), .rst(rst), .start(start), .imem_we(imem_we), .imem_addr(imem_addr),
    .imem_wdata(imem_wdata), .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .dbg_rdata(dbg_rdata), .pc(pc), .halted(halted));

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit trace_on = 0;

  // behavioural reference: 0 idle, 1 run, 2 divide stall, 3 halted
  int m_st;
  int stall;
  logic [15:0] m_pc;
  logic signed [31:0] m_bank [64];
  logic [31:0] m_imem [256];
  int pa, pb;
  logic signed [31:0] pq, pr;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic floor_div(input longint x, input longint y, output logic signed [31:0] q, output logic signed [31:0] r);
    longint qq, rr;
    qq = x / y;
    rr = x % y;
    if (rr != 0 && ((rr < 0) != (y < 0))) begin
      qq = qq - 1;
      rr = rr + y;
    end
    q = 32'(qq);
    r = 32'(rr);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0;
      m_pc = 0;
      stall = 0;
    end else begin
      if (dbg_we && (m_st == 0 || m_st == 3)) m_bank[dbg_addr] = dbg_wdata;
      case (m_st)
        0: if (start) m_st = 1;
        1: begin
          logic [31:0] w;
          int o, a, b;
          logic signed [31:0] x, y;
          w = m_imem[m_pc[7:0]];
          o = int'(w[31:28]);
          a = int'(w[27:22]);
          b = int'(w[21:16]);
          x = m_bank[a];
          y = m_bank[b];
          case (o)
            1: begin m_bank[a] = y; m_pc++; end
            2: begin m_bank[a] = 32'(longint'(x) + longint'(y)); m_pc++; end
            3: begin m_bank[a] = 32'(longint'(x) - longint'(y)); m_pc++; end
            4: begin m_bank[a] = 32'(longint'(x) * longint'(y)); m_pc++; end
            5: begin
              if (y == 0) begin
                m_bank[a] = 0;
                m_bank[b] = x;
                m_pc++;
              end else begin
                floor_div(longint'(x), longint'(y), pq, pr);
                pa = a;
                pb = b;
                stall = DW + 1;
                m_st = 2;
              end
            end
            6: m_pc = w[15:0];
            7: m_pc = (x == 0) ? w[15:0] : m_pc + 16'd1;
            8: m_pc = (x > 0) ? w[15:0] : m_pc + 16'd1;
            default: m_st = 3;
          endcase
        end
        2: begin
          stall--;
          if (stall == 0) begin
            m_bank[pa] = pq;
            m_bank[pb] = pr;
            m_pc++;
            m_st = 1;
          end
        end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (trace_on && !rst) begin
      chk(pc == m_pc, "R3 R4 R9 R10 R11 R12 R14 pc trace", pc, m_pc);
      chk(halted == (m_st == 3), "R2 halted trace", halted, (m_st == 3));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [31:0] enc(input int o, input int a, input int b, input int t);
    return {4'(o), 6'(a), 6'(b), 16'(t)};
  endfunction

  task automatic ld(input int addr, input logic [31:0] w);
    imem_we = 1;
    imem_addr = AW'(addr);
    imem_wdata = w;
    m_imem[addr] = w;
    @(negedge clk);
    imem_we = 0;
  endtask

  task automatic dwr(input int addr, input logic [31:0] v);
    dbg_we = 1;
    dbg_addr = 6'(addr);
    dbg_wdata = v;
    @(negedge clk);
    dbg_we = 0;
  endtask

  task automatic rd(input int addr, output logic [31:0] v);
    dbg_addr = 6'(addr);
    #1;
    v = dbg_rdata;
  endtask

  task automatic chk_loc(input int addr, input logic signed [31:0] exp, input string tag);
    logic [31:0] v;
    rd(addr, v);
    chk(v == exp, tag, longint'($signed(v)), longint'(exp));
  endtask

  task automatic pulse_start();
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_halt();
    while (!halted) @(negedge clk);
  endtask

  initial begin
    rst = 1; start = 0; imem_we = 0; dbg_we = 0;
    imem_addr = '0; imem_wdata = '0; dbg_addr = '0; dbg_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    trace_on = 1;
    chk(pc == 16'd0, "R1 pc after reset", pc, 0);
    chk(halted == 1'b0, "R1 halted after reset", halted, 0);
    repeat (5) @(negedge clk);
    chk(pc == 16'd0, "R1 pc idle without start", pc, 0);

    for (int i = 0; i < 64; i++) dwr(i, 32'(1000 + i));
    dwr(1, 7);           dwr(2, -2);          dwr(3, -7);         dwr(4, 2);
    dwr(5, 32'h7fffffff); dwr(9, 100);        dwr(12, 1);         dwr(20, 13);
    dwr(21, 4);          dwr(22, 32'h10000);  dwr(23, -9);        dwr(24, -4);
    dwr(25, 17);         dwr(26, 5);          dwr(27, 9);         dwr(7, 32'h80000000);
    dwr(8, -1);          dwr(28, 11);         dwr(10, 0);         dwr(29, -6);
    dwr(32, 0);          dwr(40, 0);          dwr(11, 5);         dwr(41, 0);
    dwr(42, -3);         dwr(50, 32'h123);

    ld(0, enc(1, 30, 1, 0));   ld(1, enc(2, 5, 12, 0));   ld(2, enc(3, 9, 1, 0));
    ld(3, enc(4, 20, 21, 0));  ld(4, enc(4, 22, 22, 0));  ld(5, enc(5, 1, 2, 0));
    ld(6, enc(5, 3, 4, 0));    ld(7, enc(5, 23, 24, 0));  ld(8, enc(5, 25, 26, 0));
    ld(9, enc(5, 27, 27, 0));  ld(10, enc(5, 7, 8, 0));   ld(11, enc(5, 28, 10, 0));
    ld(12, enc(5, 29, 32, 0)); ld(13, enc(7, 40, 0, 15)); ld(14, enc(0, 0, 0, 0));
    ld(15, enc(7, 11, 0, 14)); ld(16, enc(3, 11, 12, 0)); ld(17, enc(2, 41, 12, 0));
    ld(18, enc(8, 11, 0, 16)); ld(19, enc(8, 42, 0, 14)); ld(20, enc(6, 0, 0, 22));
    ld(21, enc(0, 0, 0, 0));   ld(22, enc(1, 43, 41, 0)); ld(23, enc(0, 9, 9, 5));

    pulse_start();
    repeat (10) @(negedge clk);
    dwr(50, 32'h55);
    wait_halt();
    repeat (2) @(negedge clk);

    chk(pc == 16'd23, "R2 pc parked on halt", pc, 23);
    chk_loc(30, 7, "R3 copy");
    chk_loc(5, 32'h80000000, "R4 add wraps");
    chk_loc(9, 93, "R4 subtract");
    chk_loc(20, 52, "R4 multiply");
    chk_loc(22, 0, "R4 multiply keeps low bits");
    chk_loc(1, -4, "R6 quotient 7 by -2");
    chk_loc(2, -1, "R6 remainder 7 by -2");
    chk_loc(3, -4, "R6 quotient -7 by 2");
    chk_loc(4, 1, "R6 remainder -7 by 2");
    chk_loc(23, 2, "R6 quotient -9 by -4");
    chk_loc(24, -1, "R6 remainder -9 by -4");
    chk_loc(25, 3, "R6 quotient 17 by 5");
    chk_loc(26, 2, "R6 remainder 17 by 5");
    chk_loc(7, 32'h80000000, "R6 quotient min by -1");
    chk_loc(8, 0, "R6 remainder min by -1");
    chk_loc(27, 0, "R7 shared location keeps remainder");
    chk_loc(28, 0, "R8 zero divisor quotient");
    chk_loc(10, 11, "R8 zero divisor remainder");
    chk_loc(29, 0, "R8 negative dividend quotient");
    chk_loc(32, -6, "R8 negative dividend remainder");
    chk_loc(11, 0, "R12 loop counter reached zero");
    chk_loc(41, 5, "R12 loop iterations");
    chk_loc(43, 5, "R10 jump landed on copy");
    chk_loc(50, 32'h123, "R13 write while running ignored");
    chk_loc(44, 1044, "R5 untouched location");
    for (int i = 0; i < 64; i++) chk_loc(i, m_bank[i], "R5 bank matches model");

    pulse_start();
    repeat (3) @(negedge clk);
    chk(pc == 16'd23, "R2 start after halt ignored pc", pc, 23);
    chk(halted == 1'b1, "R2 halted persists", halted, 1);
    dwr(51, 77);
    chk_loc(51, 77, "R13 write while halted");

    rst = 1;
    @(negedge clk);
    rst = 0;
    chk(halted == 1'b0, "R1 reset clears halted", halted, 0);
    chk(pc == 16'd0, "R1 reset clears pc", pc, 0);
    dwr(60, 1);
    dwr(61, 9);
    ld(0, enc(1, 60, 61, 0));
    ld(1, enc(12, 61, 60, 3));
    pulse_start();
    wait_halt();
    repeat (2) @(negedge clk);
    chk(pc == 16'd1, "R2 opcode 12 halts in place", pc, 1);
    chk_loc(60, 9, "R14 first instruction ran");
    chk_loc(61, 9, "R2 undefined opcode writes nothing");

    trace_on = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule